// File: doc/BRIEF.md
# Serial Ferroelectric Memory Slave

This block is a mode-0 serial slave that behaves like a small nonvolatile byte memory. A host lowers chip select, shifts in an 8-bit command, optionally a 24-bit address, and then streams data bytes in or out. The storage array, a status register and a write-enable latch are held in on-chip flops. Array writes pass two gates: the write-enable latch, and a block-protection window chosen by two status bits.

The serial pins are sampled by the system clock `clk_i`. Each serial edge is detected from the sampled level, so the serial clock must run several times slower than `clk_i`. A sleep command parks the device until the next chip-select frame, which wakes it.

Top module: `ferro_spi_mem`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0x00 and `sleep_o` is low.
- R2: Command 0x03 followed by three address bytes, most significant first, returns array data from that address. The low `ADDR_W` address bits select the byte and the upper bits are ignored. The address increments after each byte and wraps within the array.
- R3: Command 0x0B works like 0x03 but takes one dummy byte after the address before data is returned.
- R4: Command 0x02 plus a 24-bit address stores each following byte at successive addresses, but only when the write-enable latch is set. When the latch is clear the array is not changed.
- R5: Command 0x06 sets the write-enable latch, which is status bit 1. A frame holding command 0x04 clears it when chip select rises.
- R6: The write-enable latch clears when chip select rises at the end of a 0x02 or 0x01 frame.
- R7: Command 0x05 returns the status byte: bit 7 is the protect-enable flag, bits 3:2 are the protection code, bit 1 is the write-enable latch, and all other bits are 0. Command 0x01 loads bit 7 and bits 3:2 from its data byte only when the latch is set.
- R8: After a frame holding 0x B9 ends, `sleep_o` is high and commands are ignored, so reads return 0x00. The next frame is also ignored, and when its chip select rises the device wakes.
- R9: Protection code 1 blocks writes where the top two address bits are 11. Code 2 blocks writes where the top bit is 1. Code 3 blocks all writes. Within one burst, bytes outside the window are still stored.
- R10: Command 0x9F returns 9 identity bytes, where byte k is (0xC2 + 0x1D*k) mod 256. After those, it returns 0x00.
- R11: MOSI is sampled on the rising edge and MISO changes on the falling edge, most significant bit first. MISO is 0 while chip select is high and during the command byte. An incomplete byte at chip-select rise is discarded.
- R12: Any other command byte has no effect on the status or the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock sampling the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idle low |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out, 0 when deselected |
| sleep_o | output | 1 | High while the device sleeps |

## Verification
Two functions can act on the same data byte: the protection check and the address increment. When a write burst crosses the edge of a protection window, each byte is checked against the window at its own address. The bench provokes this with directed bursts that straddle the quarter boundary and the half boundary, and then with random writes under random protection codes. The result is judged by reading the array back and comparing it against a reference model. The sleep-and-wake pairing is also covered: the waking frame must itself be ignored.

// File: rtl/ferro_pkg.sv
package ferro_pkg;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WE_CLR  = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_WE_SET  = 8'h06;
  localparam logic [7:0] OP_FAST    = 8'h0B;
  localparam logic [7:0] OP_IDENT   = 8'h9F;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;

  typedef enum logic [3:0] {
    S_OP, S_ADDR, S_DUMMY, S_LOAD, S_RD, S_WR, S_STAT_RD, S_STAT_WR, S_ID, S_SKIP
  } st_e;

  typedef enum logic [1:0] {K_READ, K_FAST, K_WRITE} acc_e;
endpackage

// File: rtl/ferro_spi_shift.sv
module ferro_spi_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       frame_end_o
);
  logic       sclk_q, cs_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] sh_q;
  logic       rise, fall;

  assign rise        = sclk_i & ~sclk_q & ~cs_ni;
  assign fall        = ~sclk_i & sclk_q & ~cs_ni;
  assign frame_end_o = cs_ni & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      cs_q        <= 1'b1;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      miso_o      <= 1'b0;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '0;
    end else begin
      sclk_q      <= sclk_i;
      cs_q        <= cs_ni;
      byte_done_o <= 1'b0;
      if (cs_ni) begin
        bit_cnt_q <= '0;  // drops any partial byte
        miso_o    <= 1'b0;
      end else begin
        if (rise) begin
          sh_q      <= {sh_q[5:0], mosi_i};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            byte_done_o <= 1'b1;
            rx_byte_o   <= {sh_q, mosi_i};
          end
        end
        if (fall) miso_o <= tx_byte_i[~bit_cnt_q];
      end
    end
  end
endmodule

// File: rtl/ferro_mem_array.sv
module ferro_mem_array #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [1:0]        prot_i,
  output logic [7:0]        rd_data_o,
  output logic              we_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic       blocked;
  logic [1:0] top2;
  logic [7:0] words [DEPTH];

  assign top2 = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    case (prot_i)
      2'd0:    blocked = 1'b0;
      2'd1:    blocked = (top2 == 2'b11);
      2'd2:    blocked = top2[1];
      default: blocked = 1'b1;
    endcase
  end

  assign we_o      = wr_req_i & ~blocked;
  assign rd_data_o = words[addr_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [7:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q <= '0;
      else if (we_o && addr_i == ADDR_W'(g))    word_q <= wr_data_i;
    end
    assign words[g] = word_q;
  end
endmodule

// File: rtl/ferro_ctrl.sv
module ferro_ctrl
  import ferro_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          ID_LEN  = 9,
  parameter logic [7:0]  ID_SEED = 8'hC2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_done_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              frame_end_i,
  input  logic [7:0]        rd_data_i,
  output logic [7:0]        tx_byte_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [1:0]        prot_o,
  output logic              wel_o,
  output logic              sleep_o
);
  localparam int IDX_W = $clog2(ID_LEN + 1);

  st_e               st_q;
  acc_e              kind_q;
  logic [1:0]        acnt_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [7:0]        tx_q;
  logic              wel_q, wel_clr_q, wpen_q, slp_q, slp_arm_q;
  logic [1:0]        bp_q;
  logic [IDX_W-1:0]  id_idx_q;
  logic [7:0]        status;

  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] k);
    return ID_SEED + 8'(k) * 8'h1D;
  endfunction

  assign status    = {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
  assign tx_byte_o = tx_q;
  assign ptr_o     = ptr_q;
  assign prot_o    = bp_q;
  assign wel_o     = wel_q;
  assign sleep_o   = slp_q;
  assign wr_req_o  = (st_q == S_WR) && byte_done_i && wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_OP; kind_q <= K_READ; acnt_q <= '0; ptr_q <= '0; tx_q <= '0;
      wel_q <= 1'b0; wel_clr_q <= 1'b0; wpen_q <= 1'b0; bp_q <= '0;
      slp_q <= 1'b0; slp_arm_q <= 1'b0; id_idx_q <= '0;
    end else if (frame_end_i) begin
      st_q      <= S_OP;
      tx_q      <= '0;
      wel_clr_q <= 1'b0;
      slp_arm_q <= 1'b0;
      if (wel_clr_q) wel_q <= 1'b0;
      if (slp_q)          slp_q <= 1'b0;  // wake frame
      else if (slp_arm_q) slp_q <= 1'b1;
    end else begin
      case (st_q)
        S_OP: if (byte_done_i) begin
          acnt_q <= '0;
          if (slp_q) st_q <= S_SKIP;
          else begin
            case (rx_byte_i)
              OP_READ:    begin kind_q <= K_READ;  st_q <= S_ADDR; end
              OP_FAST:    begin kind_q <= K_FAST;  st_q <= S_ADDR; end
              OP_WRITE:   begin kind_q <= K_WRITE; st_q <= S_ADDR; wel_clr_q <= 1'b1; end
              OP_STAT_WR: begin st_q <= S_STAT_WR; wel_clr_q <= 1'b1; end
              OP_WE_SET:  begin wel_q <= 1'b1; st_q <= S_SKIP; end
              OP_WE_CLR:  begin wel_clr_q <= 1'b1; st_q <= S_SKIP; end
              OP_STAT_RD: begin tx_q <= status; st_q <= S_STAT_RD; end
              OP_IDENT:   begin tx_q <= id_byte('0); id_idx_q <= IDX_W'(1); st_q <= S_ID; end
              OP_SLEEP:   begin slp_arm_q <= 1'b1; st_q <= S_SKIP; end
              default:    st_q <= S_SKIP;
            endcase
          end
        end
        S_ADDR: if (byte_done_i) begin
          ptr_q  <= ADDR_W'({ptr_q, rx_byte_i});
          acnt_q <= acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            case (kind_q)
              K_WRITE: st_q <= S_WR;
              K_FAST:  st_q <= S_DUMMY;
              default: st_q <= S_LOAD;
            endcase
          end
        end
        S_DUMMY:   if (byte_done_i) st_q <= S_LOAD;
        S_LOAD: begin
          tx_q  <= rd_data_i;
          ptr_q <= ptr_q + ADDR_W'(1);
          st_q  <= S_RD;
        end
        S_RD:      if (byte_done_i) st_q <= S_LOAD;
        S_WR:      if (byte_done_i) ptr_q <= ptr_q + ADDR_W'(1);
        S_STAT_RD: if (byte_done_i) tx_q <= status;
        S_STAT_WR: if (byte_done_i) begin
          if (wel_q) begin
            bp_q   <= rx_byte_i[3:2];
            wpen_q <= rx_byte_i[7];
          end
          st_q <= S_SKIP;
        end
        S_ID: if (byte_done_i) begin
          if (id_idx_q < IDX_W'(ID_LEN)) begin
            tx_q     <= id_byte(id_idx_q);
            id_idx_q <= id_idx_q + IDX_W'(1);
          end else begin
            tx_q <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ferro_spi_mem.sv
module ferro_spi_mem #(
  parameter int         ADDR_W  = 6,
  parameter int         ID_LEN  = 9,
  parameter logic [7:0] ID_SEED = 8'hC2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o,
  output logic sleep_o
);
  logic              byte_done, frame_end, wr_req, mem_we, wel_q;
  logic [7:0]        rx_byte, tx_byte, rd_data;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]        bp_q;
  logic              miso_q;

  ferro_spi_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni), .mosi_i(mosi_i),
    .tx_byte_i(tx_byte), .miso_o(miso_q), .byte_done_o(byte_done),
    .rx_byte_o(rx_byte), .frame_end_o(frame_end)
  );

  ferro_ctrl #(.ADDR_W(ADDR_W), .ID_LEN(ID_LEN), .ID_SEED(ID_SEED)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_done_i(byte_done), .rx_byte_i(rx_byte),
    .frame_end_i(frame_end), .rd_data_i(rd_data), .tx_byte_o(tx_byte),
    .wr_req_o(wr_req), .ptr_o(ptr), .prot_o(bp_q), .wel_o(wel_q), .sleep_o(sleep_o)
  );

  ferro_mem_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_req_i(wr_req), .addr_i(ptr),
    .wr_data_i(rx_byte), .prot_i(bp_q), .rd_data_o(rd_data), .we_o(mem_we)
  );

  assign miso_o = ~cs_ni & miso_q;
endmodule

// File: rtl/ferro_spi_chk.sv
module ferro_spi_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_o,
  input logic       wel,
  input logic [1:0] bp,
  input logic       mem_we,
  input logic       byte_done,
  input logic       frame_end
);
  AST_WE_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> wel); // R4
  AST_WEL_SET_ON_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> $past(byte_done)); // R5
  AST_WEL_CLR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wel) |-> $past(frame_end)); // R6
  AST_BP_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bp) |-> $past(wel)); // R7
  AST_SLEEP_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sleep_o) |-> $past(frame_end)); // R8
  AST_NO_WRITE_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !mem_we); // R8
endmodule

bind ferro_spi_mem ferro_spi_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_o(sleep_o), .wel(wel_q), .bp(bp_q),
  .mem_we(mem_we), .byte_done(byte_done), .frame_end(frame_end)
);

// File: tb/tb_ferro_spi_mem.sv
module tb_ferro_spi_mem;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, sleep;
  int n_chk = 0, n_fail = 0;

  logic [7:0] m_mem [DEPTH];
  bit         m_wel, m_wpen, m_sleep;
  logic [1:0] m_bp;

  always #2.5 clk = ~clk;

  ferro_spi_mem dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
    .mosi_i(mosi), .miso_o(miso), .sleep_o(sleep)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit prot(input logic [AW-1:0] a, input logic [1:0] bp);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a[AW-1 -: 2] == 2'b11;
      2'd2: return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] stat();
    return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] q);
    q = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = d[i];
      wait_clk(HALF);
      q[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
    xbits(d, 8, q);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; wait_clk(3);
  endtask

  task automatic cs_hi();
    wait_clk(3); cs_n = 1'b1; wait_clk(4);
  endtask

  task automatic end_frame(input logic [7:0] op, input bit live);
    if (!live) begin m_sleep = 0; return; end
    case (op)
      8'h06: m_wel = 1;
      8'h01, 8'h02, 8'h04: m_wel = 0;
      8'hB9: m_sleep = 1;
      default: ;
    endcase
  endtask

  task automatic cmd_only(input logic [7:0] op);
    logic [7:0] q;
    bit live = !m_sleep;
    cs_lo(); xbyte(op, q); cs_hi();
    chk("R11", q, 8'h00);
    end_frame(op, live);
  endtask

  task automatic do_write(input logic [23:0] a, input int n);
    logic [7:0] q, d;
    bit live = !m_sleep;
    cs_lo(); xbyte(8'h02, q);
    xbyte(a[23:16], q); xbyte(a[15:8], q); xbyte(a[7:0], q);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ix = a[AW-1:0] + AW'(i);
      d = 8'($urandom);
      xbyte(d, q);
      if (live && m_wel && !prot(ix, m_bp)) m_mem[ix] = d;
    end
    cs_hi(); end_frame(8'h02, live);
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input bit fast, input string tag);
    logic [7:0] q;
    bit live = !m_sleep;
    cs_lo(); xbyte(fast ? 8'h0B : 8'h03, q);
    chk("R11", q, 8'h00);
    xbyte(a[23:16], q); xbyte(a[15:8], q); xbyte(a[7:0], q);
    if (fast) xbyte(8'hFF, q);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ix = a[AW-1:0] + AW'(i);
      xbyte(8'($urandom), q);
      chk(tag, q, live ? m_mem[ix] : 8'h00);
    end
    cs_hi(); end_frame(8'h03, live);
  endtask

  task automatic rd_stat(input string tag);
    logic [7:0] q;
    bit live = !m_sleep;
    cs_lo(); xbyte(8'h05, q); xbyte(8'h00, q);
    chk(tag, q, live ? stat() : 8'h00);
    xbyte(8'h00, q);
    chk(tag, q, live ? stat() : 8'h00);
    cs_hi(); end_frame(8'h05, live);
  endtask

  task automatic wr_stat(input logic [7:0] v);
    logic [7:0] q;
    bit live = !m_sleep;
    cs_lo(); xbyte(8'h01, q); xbyte(v, q); cs_hi();
    if (live && m_wel) begin m_bp = v[3:2]; m_wpen = v[7]; end
    end_frame(8'h01, live);
  endtask

  task automatic set_bp(input logic [1:0] bp);
    cmd_only(8'h06); wr_stat({6'b0, bp} << 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 8'h01, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] q;
    void'($urandom(32'h5EED_0001));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    m_wel = 0; m_wpen = 0; m_sleep = 0; m_bp = 2'd0;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);

    chk("R1", {7'b0, sleep}, 8'h00);
    chk("R11", {7'b0, miso}, 8'h00);
    rd_stat("R1");
    do_read(24'h000000, 4, 0, "R1");

    do_write(24'h000005, 2);                 // latch clear
    do_read(24'h000005, 2, 0, "R4");

    cmd_only(8'h06);
    rd_stat("R5");
    do_write(24'hA5F03E, 4);                 // wraps to 0,1; upper bits ignored
    do_read(24'h00003E, 4, 0, "R2");
    do_read(24'h7F123E, 4, 0, "R2");
    rd_stat("R6");

    cmd_only(8'h06); cmd_only(8'h04);
    rd_stat("R5");
    do_write(24'h000010, 2);
    do_read(24'h000010, 2, 0, "R4");

    wr_stat(8'h8C);
    rd_stat("R7");
    cmd_only(8'h06); wr_stat(8'h84);
    rd_stat("R7");
    rd_stat("R6");

    cmd_only(8'h06); do_write(24'h00002E, 4);   // quarter edge
    do_read(24'h00002E, 4, 0, "R9");
    set_bp(2'd2);
    cmd_only(8'h06); do_write(24'h00001E, 4);   // half edge
    do_read(24'h00001E, 4, 0, "R9");
    set_bp(2'd3);
    cmd_only(8'h06); do_write(24'h000002, 3);
    do_read(24'h000002, 3, 0, "R9");
    set_bp(2'd0);
    rd_stat("R7");

    cmd_only(8'h06); do_write(24'h000020, 5);
    do_read(24'h000020, 5, 1, "R3");

    cs_lo(); xbyte(8'h9F, q);
    for (int k = 0; k < 11; k++) begin
      xbyte(8'h00, q);
      chk("R10", q, k < 9 ? 8'(8'hC2 + 8'h1D * 8'(k)) : 8'h00);
    end
    cs_hi();

    cmd_only(8'hB9);
    chk("R8", {7'b0, sleep}, 8'h01);
    do_read(24'h000020, 2, 0, "R8");         // ignored, wakes
    chk("R8", {7'b0, sleep}, 8'h00);
    cmd_only(8'hB9);
    cmd_only(8'h06);                          // ignored wake frame
    rd_stat("R8");

    cs_lo(); xbits(8'h06, 7, q); cs_hi();     // partial byte dropped
    rd_stat("R11");
    cs_lo(); xbits(8'hFF, 3, q); cs_hi();
    rd_stat("R11");

    cmd_only(8'h06);
    cs_lo(); xbyte(8'h55, q); xbyte(8'h00, q); xbyte(8'h00, q); xbyte(8'h07, q); cs_hi();
    rd_stat("R12");
    do_read(24'h000000, 8, 0, "R12");

    for (int it = 0; it < 70; it++) begin
      logic [23:0] a = 24'($urandom);
      case ($urandom % 8)
        0: do_write(a, 1 + int'($urandom % 4));
        1: do_read(a, 1 + int'($urandom % 4), 0, "R2");
        2: do_read(a, 1 + int'($urandom % 3), 1, "R3");
        3: cmd_only(8'h06);
        4: cmd_only(8'h04);
        5: rd_stat("R7");
        6: wr_stat(8'($urandom));
        default: if ($urandom % 3 == 0) cmd_only(8'hB9); else cmd_only(8'h06);
      endcase
      chk("R8", {7'b0, sleep}, {7'b0, m_sleep});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule